// File: doc/BRIEF.md
# Working Register File with Address Pointers

This block is the general-purpose register storage of a small 8-bit processor core. It holds a bank of byte-wide registers. An execution stage reads them through two independent byte ports and one aligned 16-bit pair port, and writes results back one byte or one register pair at a time. All reads are combinational and all writes take effect on the rising clock edge. A read and the result write of the same register in one cycle therefore finish inside that single cycle, and the read returns the value from before the edge.

The low end of the data address space is an alias of the same storage. A load/store unit that presents an address below the register count reaches a register and not the memory behind it. The block reports that hit so the caller can steer the access.

The top three register pairs serve as 16-bit address pointers. The block forms an effective address from the selected pointer in one of three ways: pointer plus a small unsigned offset, the pointer itself followed by an increment, or a decrement applied before use. When an update is requested, it writes the changed pointer back in the same cycle.

Top module: `gpr_window`

## Requirements
- R1: After reset every register reads 0x00.
- R2: `rd_a_data` and `rd_b_data` return the registers selected by `rd_a_idx` and `rd_b_idx` in the same cycle. When a register is written in that cycle, its read returns the value from before the clock edge.
- R3: With `wr_en`=1 and `wr_wide`=0, `wr_data[7:0]` is stored in register `wr_idx` at the rising edge.
- R4: `rd_pair_data` is {register (idx|1), register (idx&~1)} for `rd_pair_idx`. Bit 0 of the index is ignored.
- R5: With `wr_en`=1 and `wr_wide`=1, `wr_data[7:0]` goes to the even register and `wr_data[15:8]` to the odd register of the pair named by `wr_idx`. Bit 0 of the index is ignored.
- R6: For `ds_addr` below 32, `ds_hit`=1 and `ds_rd_data` is register `ds_addr`. For any other address, `ds_hit`=0 and `ds_rd_data`=0x00.
- R7: `ds_wr_en` writes `ds_wr_data` into register `ds_addr` only when `ds_addr` is below 32. Above that, no register changes.
- R8: `ptr_sel` picks the pointer: 0 uses registers 27:26, 1 uses 29:28, 2 uses 31:30, and 3 is treated as 2. The low byte is the even register.
- R9: `ptr_mode` 00 or 11 (offset) gives `ptr_addr` = pointer + zero-extended `ptr_disp`, modulo 2^16. The pointer is never written back.
- R10: `ptr_mode` 01 (post-increment) gives `ptr_addr` = pointer. With `ptr_en`=1 the pointer becomes pointer+1 modulo 2^16 at the edge.
- R11: `ptr_mode` 10 (pre-decrement) gives `ptr_addr` = pointer−1 modulo 2^16. With `ptr_en`=1 that value is written back to the pointer at the edge.
- R12: When several writes hit the same register in one cycle, each byte takes the port write first, then the pointer update, then the data-space write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 5 | First byte read index |
| rd_a_data | output | 8 | First byte read data |
| rd_b_idx | input | 5 | Second byte read index |
| rd_b_data | output | 8 | Second byte read data |
| rd_pair_idx | input | 5 | Pair read index (bit 0 ignored) |
| rd_pair_data | output | 16 | Pair read data, odd register in the high byte |
| wr_en | input | 1 | Result write enable |
| wr_wide | input | 1 | 1 = write a 16-bit pair, 0 = write one byte |
| wr_idx | input | 5 | Result write index |
| wr_data | input | 16 | Result data (low byte only for byte writes) |
| ds_addr | input | 16 | Data-space address |
| ds_wr_en | input | 1 | Data-space write enable |
| ds_wr_data | input | 8 | Data-space write data |
| ds_hit | output | 1 | Address falls in the register window |
| ds_rd_data | output | 8 | Data-space read data, 0 on a miss |
| ptr_en | input | 1 | Apply the pointer update of the selected mode |
| ptr_sel | input | 2 | Pointer select |
| ptr_mode | input | 2 | 00/11 offset, 01 post-increment, 10 pre-decrement |
| ptr_disp | input | 6 | Unsigned offset for offset mode |
| ptr_addr | output | 16 | Effective address |

## Verification
A table of scattered register indices and byte values is written through the result port. Each entry is read back through both byte ports and through the data-space alias. This separates a wrong index decode from a wrong data path and from a broken alias. Pair reads and writes use an odd index, which shows whether bit 0 is really ignored and whether the bytes land in the right order. Pointer tests start from 0xFFFF and 0x0000 to expose wrap faults, and use select value 3 to check the alias to the last pointer. Collision cycles put two writers on the same byte to show the priority order, and they leave the other byte of the pair to show which writer owns it.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

   // Pointer address-generation modes
   typedef enum logic [1:0] {
      PM_OFFSET  = 2'b00,
      PM_POSTINC = 2'b01,
      PM_PREDEC  = 2'b10,
      PM_OFFSET2 = 2'b11
   } ptr_mode_e;

endpackage

// File: rtl/gpr_store.sv
module gpr_store #(
   parameter int REG_W     = 8,
   parameter int REG_COUNT = 32,
   localparam int IDX_W    = $clog2(REG_COUNT),
   localparam int PAIR_W   = 2 * REG_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       wr_wide,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [PAIR_W-1:0]          wr_data,
   input  logic                       pw_en,
   input  logic [IDX_W-1:0]           pw_idx,
   input  logic [PAIR_W-1:0]          pw_value,
   input  logic                       dw_en,
   input  logic [IDX_W-1:0]           dw_idx,
   input  logic [REG_W-1:0]           dw_data,
   output logic [REG_COUNT*REG_W-1:0] file_q
);

   for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
      logic             port_hit;
      logic             ptr_hit;
      logic             ds_hit_w;
      logic [REG_W-1:0] port_byte;
      logic [REG_W-1:0] ptr_byte;
      logic [REG_W-1:0] q;

      always_comb begin
         if (wr_wide)
            port_hit = wr_en && (wr_idx[IDX_W-1:1] == MY_IDX[IDX_W-1:1]);
         else
            port_hit = wr_en && (wr_idx == MY_IDX);
         port_byte = (wr_wide && MY_IDX[0]) ? wr_data[PAIR_W-1:REG_W]
                                            : wr_data[REG_W-1:0];
         ptr_hit   = pw_en && (pw_idx[IDX_W-1:1] == MY_IDX[IDX_W-1:1]);
         ptr_byte  = MY_IDX[0] ? pw_value[PAIR_W-1:REG_W] : pw_value[REG_W-1:0];
         ds_hit_w  = dw_en && (dw_idx == MY_IDX);
      end

      // priority: result port, then pointer update, then data space
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (port_hit)
            q <= port_byte;
         else if (ptr_hit)
            q <= ptr_byte;
         else if (ds_hit_w)
            q <= dw_data;
      end

      assign file_q[i*REG_W +: REG_W] = q;
   end

endmodule

// File: rtl/gpr_read.sv
module gpr_read #(
   parameter int REG_W     = 8,
   parameter int REG_COUNT = 32,
   parameter int DS_W      = 16,
   localparam int IDX_W    = $clog2(REG_COUNT),
   localparam int PAIR_W   = 2 * REG_W
) (
   input  logic [REG_COUNT*REG_W-1:0] file_q,
   input  logic [IDX_W-1:0]           rd_a_idx,
   input  logic [IDX_W-1:0]           rd_b_idx,
   input  logic [IDX_W-1:0]           rd_pair_idx,
   input  logic [DS_W-1:0]            ds_addr,
   output logic [REG_W-1:0]           rd_a_data,
   output logic [REG_W-1:0]           rd_b_data,
   output logic [PAIR_W-1:0]          rd_pair_data,
   output logic                       ds_hit,
   output logic [IDX_W-1:0]           ds_idx,
   output logic [REG_W-1:0]           ds_rd_data
);

   logic [IDX_W-1:0] pair_lo;
   logic [IDX_W-1:0] pair_hi;

   always_comb begin
      pair_lo      = {rd_pair_idx[IDX_W-1:1], 1'b0};
      pair_hi      = {rd_pair_idx[IDX_W-1:1], 1'b1};
      rd_a_data    = file_q[rd_a_idx*REG_W +: REG_W];
      rd_b_data    = file_q[rd_b_idx*REG_W +: REG_W];
      rd_pair_data = {file_q[pair_hi*REG_W +: REG_W], file_q[pair_lo*REG_W +: REG_W]};
      ds_hit       = (ds_addr < DS_W'(REG_COUNT));
      ds_idx       = ds_addr[IDX_W-1:0];
      ds_rd_data   = ds_hit ? file_q[ds_idx*REG_W +: REG_W] : '0;
   end

endmodule

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit
   import gpr_pkg::*;
#(
   parameter int REG_W     = 8,
   parameter int REG_COUNT = 32,
   parameter int PTR_FIRST = 26,
   parameter int PTR_COUNT = 3,
   parameter int DISP_W    = 6,
   localparam int IDX_W    = $clog2(REG_COUNT),
   localparam int PAIR_W   = 2 * REG_W,
   localparam int SEL_W    = (PTR_COUNT > 1) ? $clog2(PTR_COUNT) : 1
) (
   input  logic [REG_COUNT*REG_W-1:0] file_q,
   input  logic                       ptr_en,
   input  logic [SEL_W-1:0]           ptr_sel,
   input  logic [1:0]                 ptr_mode,
   input  logic [DISP_W-1:0]          ptr_disp,
   output logic [PAIR_W-1:0]          ptr_addr,
   output logic                       pw_en,
   output logic [IDX_W-1:0]           pw_idx,
   output logic [PAIR_W-1:0]          pw_value
);

   logic [SEL_W-1:0]  sel_eff;
   logic [PAIR_W-1:0] cur;
   ptr_mode_e         mode;

   always_comb begin
      sel_eff  = (int'(ptr_sel) >= PTR_COUNT) ? SEL_W'(PTR_COUNT - 1) : ptr_sel;
      pw_idx   = IDX_W'(PTR_FIRST) + IDX_W'({sel_eff, 1'b0});
      cur      = {file_q[(pw_idx + IDX_W'(1))*REG_W +: REG_W], file_q[pw_idx*REG_W +: REG_W]};
      mode     = ptr_mode_e'(ptr_mode);
      pw_en    = 1'b0;
      pw_value = cur;
      ptr_addr = cur + PAIR_W'(ptr_disp);
      unique case (mode)
         PM_POSTINC: begin
            ptr_addr = cur;
            pw_value = cur + PAIR_W'(1);
            pw_en    = ptr_en;
         end
         PM_PREDEC: begin
            ptr_addr = cur - PAIR_W'(1);
            pw_value = cur - PAIR_W'(1);
            pw_en    = ptr_en;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/gpr_window.sv
module gpr_window #(
   parameter int REG_W     = 8,
   parameter int REG_COUNT = 32,
   parameter int PTR_FIRST = 26,
   parameter int PTR_COUNT = 3,
   parameter int DS_W      = 16,
   parameter int DISP_W    = 6,
   localparam int IDX_W    = $clog2(REG_COUNT),
   localparam int PAIR_W   = 2 * REG_W,
   localparam int SEL_W    = (PTR_COUNT > 1) ? $clog2(PTR_COUNT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [REG_W-1:0]  rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [REG_W-1:0]  rd_b_data,
   input  logic [IDX_W-1:0]  rd_pair_idx,
   output logic [PAIR_W-1:0] rd_pair_data,
   input  logic              wr_en,
   input  logic              wr_wide,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [PAIR_W-1:0] wr_data,
   input  logic [DS_W-1:0]   ds_addr,
   input  logic              ds_wr_en,
   input  logic [REG_W-1:0]  ds_wr_data,
   output logic              ds_hit,
   output logic [REG_W-1:0]  ds_rd_data,
   input  logic              ptr_en,
   input  logic [SEL_W-1:0]  ptr_sel,
   input  logic [1:0]        ptr_mode,
   input  logic [DISP_W-1:0] ptr_disp,
   output logic [PAIR_W-1:0] ptr_addr
);

   if ((PTR_FIRST % 2) != 0) begin : g_bad_align
      $error("gpr_window: pointer base must be an even register");
   end
   if (PTR_FIRST + 2 * PTR_COUNT > REG_COUNT) begin : g_bad_span
      $error("gpr_window: pointers exceed the register count");
   end
   if ((1 << IDX_W) != REG_COUNT) begin : g_bad_count
      $error("gpr_window: register count must be a power of two");
   end
   if (DS_W < IDX_W || DS_W > PAIR_W) begin : g_bad_ds
      $error("gpr_window: data-space width out of range");
   end

   logic [REG_COUNT*REG_W-1:0] file_q;
   logic                       pw_en;
   logic [IDX_W-1:0]           pw_idx;
   logic [PAIR_W-1:0]          pw_value;
   logic [IDX_W-1:0]           ds_idx;

   gpr_store #(.REG_W(REG_W), .REG_COUNT(REG_COUNT)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_wide  (wr_wide),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .pw_en    (pw_en),
      .pw_idx   (pw_idx),
      .pw_value (pw_value),
      .dw_en    (ds_wr_en && ds_hit),
      .dw_idx   (ds_idx),
      .dw_data  (ds_wr_data),
      .file_q   (file_q)
   );

   gpr_read #(.REG_W(REG_W), .REG_COUNT(REG_COUNT), .DS_W(DS_W)) i_read (
      .file_q       (file_q),
      .rd_a_idx     (rd_a_idx),
      .rd_b_idx     (rd_b_idx),
      .rd_pair_idx  (rd_pair_idx),
      .ds_addr      (ds_addr),
      .rd_a_data    (rd_a_data),
      .rd_b_data    (rd_b_data),
      .rd_pair_data (rd_pair_data),
      .ds_hit       (ds_hit),
      .ds_idx       (ds_idx),
      .ds_rd_data   (ds_rd_data)
   );

   gpr_ptr_unit #(
      .REG_W(REG_W), .REG_COUNT(REG_COUNT), .PTR_FIRST(PTR_FIRST),
      .PTR_COUNT(PTR_COUNT), .DISP_W(DISP_W)
   ) i_ptr (
      .file_q   (file_q),
      .ptr_en   (ptr_en),
      .ptr_sel  (ptr_sel),
      .ptr_mode (ptr_mode),
      .ptr_disp (ptr_disp),
      .ptr_addr (ptr_addr),
      .pw_en    (pw_en),
      .pw_idx   (pw_idx),
      .pw_value (pw_value)
   );

endmodule

// File: rtl/gpr_window_checker.sv
module gpr_window_checker #(
   parameter int REG_W     = 8,
   parameter int REG_COUNT = 32,
   parameter int PTR_FIRST = 26,
   parameter int PTR_COUNT = 3,
   localparam int IDX_W    = $clog2(REG_COUNT),
   localparam int PAIR_W   = 2 * REG_W,
   localparam int SEL_W    = (PTR_COUNT > 1) ? $clog2(PTR_COUNT) : 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic                       wr_wide,
   input logic [IDX_W-1:0]           wr_idx,
   input logic [PAIR_W-1:0]          wr_data,
   input logic                       ptr_en,
   input logic [SEL_W-1:0]           ptr_sel,
   input logic [1:0]                 ptr_mode,
   input logic [PAIR_W-1:0]          ptr_addr,
   input logic                       ds_hit,
   input logic [REG_W-1:0]           ds_rd_data,
   input logic [REG_COUNT*REG_W-1:0] file_q
);

   logic [IDX_W-1:0]  wr_idx_d;
   logic [PAIR_W-1:0] wr_data_d;
   logic [SEL_W-1:0]  sel_d;
   logic [IDX_W-1:0]  lo_d;
   logic [PAIR_W-1:0] ptr_now;
   logic [PAIR_W-1:0] pair_now;

   always_ff @(posedge clk) begin
      wr_idx_d  <= wr_idx;
      wr_data_d <= wr_data;
      sel_d     <= ptr_sel;
   end

   always_comb begin
      lo_d     = IDX_W'(PTR_FIRST) +
                 IDX_W'({((int'(sel_d) >= PTR_COUNT) ? SEL_W'(PTR_COUNT - 1) : sel_d), 1'b0});
      ptr_now  = {file_q[(lo_d + IDX_W'(1))*REG_W +: REG_W], file_q[lo_d*REG_W +: REG_W]};
      pair_now = {file_q[{wr_idx_d[IDX_W-1:1], 1'b1}*REG_W +: REG_W],
                  file_q[{wr_idx_d[IDX_W-1:1], 1'b0}*REG_W +: REG_W]};
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (file_q == '0));

   assert_byte_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_wide) |=> (file_q[wr_idx_d*REG_W +: REG_W] == wr_data_d[REG_W-1:0]));

   assert_pair_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_wide) |=> (pair_now == wr_data_d));

   assert_ds_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ds_hit |-> (ds_rd_data == '0));

   assert_postinc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_en && ptr_mode == 2'b01 && !wr_en) |=> (ptr_now == $past(ptr_addr) + PAIR_W'(1)));

   assert_predec_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_en && ptr_mode == 2'b10 && !wr_en) |=> (ptr_now == $past(ptr_addr)));

endmodule

bind gpr_window gpr_window_checker #(
   .REG_W(REG_W), .REG_COUNT(REG_COUNT), .PTR_FIRST(PTR_FIRST), .PTR_COUNT(PTR_COUNT)
) i_gpr_window_checker (.*);

// File: tb/test_gpr_window.sv
`timescale 1ns/1ps
module test_gpr_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd_a_idx, rd_b_idx, rd_pair_idx, wr_idx;
   logic [7:0]  rd_a_data, rd_b_data, ds_wr_data, ds_rd_data;
   logic [15:0] rd_pair_data, wr_data, ds_addr, ptr_addr;
   logic        wr_en, wr_wide, ds_wr_en, ds_hit, ptr_en;
   logic [1:0]  ptr_sel, ptr_mode;
   logic [5:0]  ptr_disp;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [32];

   always #2.5 clk = ~clk;

   gpr_window i_gpr_window (.*);

   // {index, value} pairs written through the result port and read back
   localparam logic [12:0] VEC [12] = '{
      {5'd0, 8'hA5},  {5'd31, 8'h5A}, {5'd1, 8'h01},  {5'd16, 8'h80},
      {5'd15, 8'hFF}, {5'd7, 8'h3C},  {5'd6, 8'hC3},  {5'd20, 8'h42},
      {5'd5, 8'h11},  {5'd26, 8'h9E}, {5'd13, 8'h00}, {5'd30, 8'h77}
   };

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      wr_en = 0; wr_wide = 0; wr_idx = 0; wr_data = 0;
      ds_wr_en = 0; ds_wr_data = 0; ptr_en = 0;
   endtask

   task automatic step();
      @(posedge clk); #1; idle();
   endtask

   task automatic put8(input logic [4:0] idx, input logic [7:0] val);
      @(negedge clk); wr_en = 1; wr_wide = 0; wr_idx = idx; wr_data = {8'h00, val};
      step(); model[idx] = val;
   endtask

   task automatic put16(input logic [4:0] idx, input logic [15:0] val);
      @(negedge clk); wr_en = 1; wr_wide = 1; wr_idx = idx; wr_data = val;
      step(); model[{idx[4:1], 1'b0}] = val[7:0]; model[{idx[4:1], 1'b1}] = val[15:8];
   endtask

   task automatic pair(input logic [4:0] idx, input string req, input logic [15:0] exp);
      rd_pair_idx = idx; #1; chk(req, rd_pair_data, exp);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      idle();
      rd_a_idx = 0; rd_b_idx = 0; rd_pair_idx = 0; ds_addr = 0;
      ptr_sel = 0; ptr_mode = 0; ptr_disp = 0;
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: reset contents
      for (int i = 0; i < 32; i++) begin
         rd_a_idx = 5'(i); #1; chk("R1", {8'h00, rd_a_data}, 16'h0000);
      end

      // R3 / R2 / R6: vector table
      for (int v = 0; v < 12; v++) begin
         put8(VEC[v][12:8], VEC[v][7:0]);
         rd_a_idx = VEC[v][12:8]; rd_b_idx = VEC[(v + 1) % 12][12:8];
         ds_addr = {11'h000, VEC[v][12:8]}; #1;
         chk("R3", {8'h00, rd_a_data}, {8'h00, VEC[v][7:0]});
         chk("R2", {8'h00, rd_b_data}, {8'h00, model[VEC[(v + 1) % 12][12:8]]});
         chk("R6", {7'h00, ds_hit, ds_rd_data}, {7'h00, 1'b1, VEC[v][7:0]});
      end

      // R2: same-cycle read returns the old value
      @(negedge clk); wr_en = 1; wr_idx = 5'd5; wr_data = 16'h00E4; rd_a_idx = 5'd5; #1;
      chk("R2", {8'h00, rd_a_data}, 16'h0011);
      step(); model[5] = 8'hE4;
      chk("R2", {8'h00, rd_a_data}, 16'h00E4);

      // R4: pair read with odd index
      pair(5'd7, "R4", 16'h3CC3);

      // R5: wide write with odd index
      put16(5'd9, 16'hBEEF);
      rd_a_idx = 5'd8; #1; chk("R5", {8'h00, rd_a_data}, 16'h00EF);
      rd_a_idx = 5'd9; #1; chk("R5", {8'h00, rd_a_data}, 16'h00BE);

      // R6: miss above the window
      ds_addr = 16'h0020; #1; chk("R6", {7'h00, ds_hit, ds_rd_data}, 16'h0000);
      ds_addr = 16'h001F; #1; chk("R6", {7'h00, ds_hit, ds_rd_data}, {7'h00, 1'b1, model[31]});

      // R7: data-space write ignored above window, applied inside
      @(negedge clk); ds_addr = 16'h0105; ds_wr_en = 1; ds_wr_data = 8'h77; step();
      rd_a_idx = 5'd5; #1; chk("R7", {8'h00, rd_a_data}, 16'h00E4);
      @(negedge clk); ds_addr = 16'h000C; ds_wr_en = 1; ds_wr_data = 8'h99; step();
      rd_a_idx = 5'd12; #1; chk("R7", {8'h00, rd_a_data}, 16'h0099);

      // R8 / R9: offset mode, no write-back
      put16(5'd26, 16'h1234);
      ptr_sel = 0; ptr_mode = 2'b00; ptr_disp = 6'd5; #1;
      chk("R9", ptr_addr, 16'h1239);
      @(negedge clk); ptr_en = 1; step();
      pair(5'd26, "R9", 16'h1234);
      put16(5'd30, 16'hFFF0);
      ptr_sel = 2'd3; ptr_mode = 2'b11; ptr_disp = 6'd63; #1;
      chk("R8", ptr_addr, 16'h002F);
      put16(5'd28, 16'h0A0B);
      ptr_sel = 2'd1; ptr_mode = 2'b00; ptr_disp = 6'd0; #1;
      chk("R8", ptr_addr, 16'h0A0B);

      // R10: post-increment with wrap
      put16(5'd28, 16'hFFFF);
      ptr_sel = 2'd1; ptr_mode = 2'b01; #1;
      chk("R10", ptr_addr, 16'hFFFF);
      @(negedge clk); ptr_en = 1; step();
      pair(5'd28, "R10", 16'h0000);

      // R11: pre-decrement with wrap
      put16(5'd30, 16'h0000);
      ptr_sel = 2'd2; ptr_mode = 2'b10; #1;
      chk("R11", ptr_addr, 16'hFFFF);
      @(negedge clk); ptr_en = 1; step();
      pair(5'd30, "R11", 16'hFFFF);

      // R12: port write beats pointer update on the low byte
      put16(5'd26, 16'h1000);
      @(negedge clk); ptr_sel = 0; ptr_mode = 2'b01; ptr_en = 1;
      wr_en = 1; wr_idx = 5'd26; wr_data = 16'h00AA; step();
      pair(5'd26, "R12", 16'h10AA);
      // R12: port write beats data-space write
      @(negedge clk); ds_addr = 16'h0003; ds_wr_en = 1; ds_wr_data = 8'h11;
      wr_en = 1; wr_idx = 5'd3; wr_data = 16'h0022; step();
      rd_a_idx = 5'd3; #1; chk("R12", {8'h00, rd_a_data}, 16'h0022);
      // R12: pointer update beats data-space write
      put16(5'd28, 16'h00FE);
      @(negedge clk); ptr_sel = 2'd1; ptr_mode = 2'b01; ptr_en = 1;
      ds_addr = 16'h001C; ds_wr_en = 1; ds_wr_data = 8'h55; step();
      pair(5'd28, "R12", 16'h00FF);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule